// File: doc/BRIEF.md
# Synchronous Slave FIFO Read Port

This block is the read side of a bank of FIFO buffers that an external master drains over a synchronous slave interface. Everything happens on one interface clock. The master picks a FIFO with a select field. Three active-low controls set what happens on the bus:

- a chip select,
- a read strobe,
- an output enable.

The word at the head of the selected FIFO is always prefetched. It appears on the bus as soon as the output enable and chip select are low. The read strobe does only one thing: on a clock edge it moves the selected FIFO's read pointer to the next word. Holding the strobe low over several edges gives a burst.

Each FIFO keeps its own storage, write position, read position and empty flag. Words enter through a simple internal push port. The external tri-state bus is modelled as a data vector plus a drive-enable output. A read aimed at an empty FIFO is dropped and raises a one-cycle underflow pulse.

Top module: `sfifo_rd_port`

## Requirements
- R1: A synchronous active-high `rst` empties every FIFO. After the reset edge, all bits of `empty` are 1, `rd_underflow` is 0 and no prefetched word remains.
- R2: While `bus_oe` is 1, `bus_data` shows the oldest unread word of the FIFO chosen by `fifo_sel`, with no read strobe needed. It shows 0 when that FIFO is empty.
- R3: A read takes place only on a rising edge where `cs_n` and `rd_n` are both 0. If `rd_n` is low while `cs_n` is high, the pointer stays where it is.
- R4: Each read edge on a non-empty FIFO moves its read pointer by exactly one word. Keeping `rd_n` low on consecutive edges returns the words N, N+1, N+2 and so on, one per cycle.
- R5: `oe_n` has no effect on any pointer or flag. It only controls whether the bus is driven.
- R6: `bus_oe` is 1 exactly when `cs_n` and `oe_n` are both 0, in the same cycle.
- R7: While `bus_oe` is 0, `bus_data` is all zeros.
- R8: Bit i of `empty` belongs to FIFO i, and each FIFO has its own pointers. The flag changes on the same edge as the read or push that changes the FIFO's fill.
- R9: A read aimed at an empty FIFO is ignored. `rd_underflow` is 1 for the single cycle that follows that edge.
- R10: A push into a FIFO that already holds DEPTH words is dropped. A push and a read on the same FIFO in the same cycle both take effect.
- R11: When `push_en` is 1 on an edge, `push_data` is appended to the FIFO whose index is given by `push_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fifo_sel | input | SEL_W | Index of the FIFO the master addresses |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| bus_data | output | DATA_W | Data placed on the external bus |
| bus_oe | output | 1 | High when the bus is driven |
| empty | output | NUM_FIFO | Per-FIFO empty flags |
| rd_underflow | output | 1 | One-cycle pulse after a read of an empty FIFO |
| push_en | input | 1 | Internal write request |
| push_sel | input | SEL_W | FIFO that receives the pushed word |
| push_data | input | DATA_W | Word to append |

## Verification
`bus_oe` and `bus_data` are combinational outputs. They follow `fifo_sel`, `cs_n` and `oe_n` in the same cycle and reflect the pointer state as of the previous edge. The pointer moves, the `empty` flags and `rd_underflow` all change one edge after the stimulus that causes them.

The bench drives every input on the falling edge and updates its reference model at that moment for the next rising edge. It compares every output on the following falling edge, so each result is checked exactly one edge after its cause, with the inputs still held.

// File: rtl/sfrd_pkg.sv
package sfrd_pkg;

   function automatic bit sfrd_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sfrd_lane.sv
module sfrd_lane #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] head_o,
   output logic              empty_o
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     rd_ptr;
   logic [AW-1:0]     wr_ptr;
   logic [CW-1:0]     fill;
   logic              push_ok;
   logic              pop_ok;

   assign pop_ok  = pop_i && (fill != '0);
   assign push_ok = push_i && (fill != CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= push_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         fill   <= '0;
      end else begin
         if (pop_ok) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         if (push_ok) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         case ({push_ok, pop_ok})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   assign empty_o = (fill == '0);
   assign head_o  = empty_o ? '0 : mem[rd_ptr];

   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
      pop_ok |=> rd_ptr == $past(rd_ptr) + 1'b1);

   assert_empty_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (pop_i && empty_o) |=> $stable(rd_ptr));

   assert_drain_flag_R8: assert property (@(posedge clk) disable iff (rst)
      (fill == CW'(1) && pop_i && !push_i) |=> empty_o);

   assert_fill_bound_R10: assert property (@(posedge clk) disable iff (rst)
      fill <= CW'(DEPTH));

endmodule

// File: rtl/sfrd_busctl.sv
module sfrd_busctl #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_FIFO  = 4,
   parameter bit          PARK_ZERO = 1'b1,
   localparam int unsigned SEL_W    = $clog2(NUM_FIFO)
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic [NUM_FIFO-1:0][DATA_W-1:0]    heads_i,
   input  logic [SEL_W-1:0]                   sel_i,
   input  logic                               cs_n,
   input  logic                               oe_n,
   output logic [DATA_W-1:0]                  bus_data,
   output logic                               bus_oe
);
   logic [DATA_W-1:0] picked;

   assign bus_oe = !cs_n && !oe_n;
   assign picked = heads_i[sel_i];

   generate
      if (PARK_ZERO) begin : g_park
         assign bus_data = bus_oe ? picked : '0;

         assert_park_zero_R7: assert property (@(posedge clk) disable iff (rst)
            !bus_oe |-> bus_data == '0);
      end else begin : g_pass
         assign bus_data = picked;
      end
   endgenerate

   assert_drive_follows_R2: assert property (@(posedge clk) disable iff (rst)
      bus_oe |-> bus_data == heads_i[sel_i]);

endmodule

// File: rtl/sfifo_rd_port.sv
module sfifo_rd_port
   import sfrd_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned NUM_FIFO  = 4,
   parameter bit          PARK_ZERO = 1'b1,
   localparam int unsigned SEL_W    = $clog2(NUM_FIFO)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SEL_W-1:0]    fifo_sel,
   input  logic                cs_n,
   input  logic                rd_n,
   input  logic                oe_n,
   output logic [DATA_W-1:0]   bus_data,
   output logic                bus_oe,
   output logic [NUM_FIFO-1:0] empty,
   output logic                rd_underflow,
   input  logic                push_en,
   input  logic [SEL_W-1:0]    push_sel,
   input  logic [DATA_W-1:0]   push_data
);
   generate
      if (!sfrd_pow2(DEPTH)) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (!sfrd_pow2(NUM_FIFO)) begin : g_bad_count
         $error("NUM_FIFO must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   logic                            read_req;
   logic [NUM_FIFO-1:0]             pop_vec;
   logic [NUM_FIFO-1:0]             push_vec;
   logic [NUM_FIFO-1:0][DATA_W-1:0] heads;

   assign read_req = !cs_n && !rd_n;

   generate
      for (genvar i = 0; i < NUM_FIFO; i++) begin : g_lane
         assign pop_vec[i]  = read_req && (fifo_sel == SEL_W'(i));
         assign push_vec[i] = push_en && (push_sel == SEL_W'(i));

         sfrd_lane #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
         ) u_lane (
            .clk         (clk),
            .rst         (rst),
            .push_i      (push_vec[i]),
            .push_data_i (push_data),
            .pop_i       (pop_vec[i]),
            .head_o      (heads[i]),
            .empty_o     (empty[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_underflow <= 1'b0;
      end else begin
         rd_underflow <= read_req && empty[fifo_sel];
      end
   end

   sfrd_busctl #(
      .DATA_W    (DATA_W),
      .NUM_FIFO  (NUM_FIFO),
      .PARK_ZERO (PARK_ZERO)
   ) u_bus (
      .clk      (clk),
      .rst      (rst),
      .heads_i  (heads),
      .sel_i    (fifo_sel),
      .cs_n     (cs_n),
      .oe_n     (oe_n),
      .bus_data (bus_data),
      .bus_oe   (bus_oe)
   );

   assert_underflow_cause_R9: assert property (@(posedge clk) disable iff (rst)
      rd_underflow |-> $past(!cs_n && !rd_n && empty[fifo_sel]));

   assert_cs_gate_R3: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> !rd_underflow);

   assert_reset_empty_R1: assert property (@(posedge clk)
      $past(rst) |-> (&empty) && !rd_underflow);

endmodule

// File: tb/sfifo_rd_port_test.sv
module sfifo_rd_port_test;
   localparam int DW = 16;
   localparam int DP = 8;
   localparam int NF = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    fifo_sel = '0;
   logic          cs_n = 1'b1, rd_n = 1'b1, oe_n = 1'b1;
   logic [DW-1:0] bus_data;
   logic          bus_oe;
   logic [NF-1:0] empty;
   logic          rd_underflow;
   logic          push_en = 1'b0;
   logic [1:0]    push_sel = '0;
   logic [DW-1:0] push_data = '0;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [DW-1:0] mdl [NF][DP];
   int            mhead [NF];
   int            mcnt [NF];
   bit            muf;

   always #5 clk = ~clk;

   sfifo_rd_port #(.DATA_W(DW), .DEPTH(DP), .NUM_FIFO(NF)) uut (
      .clk(clk), .rst(rst), .fifo_sel(fifo_sel), .cs_n(cs_n), .rd_n(rd_n),
      .oe_n(oe_n), .bus_data(bus_data), .bus_oe(bus_oe), .empty(empty),
      .rd_underflow(rd_underflow), .push_en(push_en), .push_sel(push_sel),
      .push_data(push_data));

   function automatic logic [DW-1:0] exp_data();
      if (cs_n || oe_n) return '0;
      if (mcnt[fifo_sel] == 0) return '0;
      return mdl[fifo_sel][mhead[fifo_sel]];
   endfunction

   function automatic logic [NF-1:0] exp_empty();
      logic [NF-1:0] e;
      for (int f = 0; f < NF; f++) e[f] = (mcnt[f] == 0);
      return e;
   endfunction

   task automatic cmp(input string tag, input string ctx,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s (%s): actual=%h expected=%h", tag, ctx, act, exp);
      end
   endtask

   task automatic check_all(input string ctx);
      cmp("R6", ctx, DW'(bus_oe), DW'(!cs_n && !oe_n));
      if (!cs_n && !oe_n) cmp("R2", ctx, bus_data, exp_data());
      else                cmp("R7", ctx, bus_data, '0);
      cmp("R8", ctx, DW'(empty), DW'(exp_empty()));
      cmp("R9", ctx, DW'(rd_underflow), DW'(muf));
   endtask

   task automatic model_reset();
      for (int f = 0; f < NF; f++) begin
         mhead[f] = 0;
         mcnt[f]  = 0;
      end
      muf = 0;
   endtask

   // drive at negedge, advance model to the next rising edge, check at the next negedge
   task automatic step(input logic [1:0] s, input bit cs, input bit rd, input bit oe,
                       input bit pu, input logic [1:0] ps, input logic [DW-1:0] pd,
                       input string ctx);
      bit valid;
      bit do_pop;
      bit do_push;
      fifo_sel = s; cs_n = cs; rd_n = rd; oe_n = oe;
      push_en = pu; push_sel = ps; push_data = pd;
      valid   = !cs && !rd;
      do_pop  = valid && mcnt[s] > 0;
      do_push = pu && mcnt[ps] < DP;
      muf     = valid && mcnt[s] == 0;
      if (do_push) mdl[ps][(mhead[ps] + mcnt[ps]) % DP] = pd;
      if (do_pop) begin
         mhead[s] = (mhead[s] + 1) % DP;
         mcnt[s]--;
      end
      if (do_push) mcnt[ps]++;
      @(posedge clk);
      @(negedge clk);
      check_all(ctx);
   endtask

   task automatic idle(input logic [1:0] s, input bit oe, input string ctx);
      step(s, 1'b0, 1'b1, oe, 1'b0, 2'd0, '0, ctx);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state; bus enabled on an empty FIFO shows zero
      cmp("R1", "reset flags", DW'(empty), DW'({NF{1'b1}}));
      cmp("R1", "reset underflow", DW'(rd_underflow), '0);
      step(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, '0, "R1 empty prefetch");

      // R11: fill FIFO 1 through the push port
      for (int k = 0; k < 4; k++)
         step(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, DW'(16'h1000 + k), "R11 push");
      // R2: head word visible with no strobe
      idle(2'd1, 1'b0, "R2 prefetch");
      // R3: strobe with chip select high does nothing
      step(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R3 no cs");
      idle(2'd1, 1'b0, "R3 after");
      cmp("R3", "head kept", bus_data, 16'h1000);
      // R5: toggling output enable never moves the pointer
      for (int k = 0; k < 4; k++) idle(2'd1, bit'(k & 1), "R5 oe toggle");
      idle(2'd1, 1'b0, "R5 after");
      cmp("R5", "head kept", bus_data, 16'h1000);
      // R4: single read, gap with bus off, then a burst
      step(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R4 single");
      cmp("R4", "single next", bus_data, 16'h1001);
      idle(2'd1, 1'b1, "R7 gap");
      step(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R4 burst");
      cmp("R4", "burst 1", bus_data, 16'h1002);
      step(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R4 burst");
      cmp("R4", "burst 2", bus_data, 16'h1003);
      step(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R4 burst drain");
      // R9: read of an empty FIFO
      step(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R9 underflow");
      cmp("R9", "pulse", DW'(rd_underflow), DW'(1));
      idle(2'd1, 1'b0, "R9 pulse ends");

      // R10: overfill FIFO 2, then drain it in one burst
      for (int k = 0; k < DP + 2; k++)
         step(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, DW'(16'h2000 + k), "R10 fill");
      for (int k = 0; k < DP; k++) begin
         idle(2'd2, 1'b0, "R10 drain look");
         cmp("R10", "drain word", bus_data, DW'(16'h2000 + k));
         step(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R10 drain");
      end
      cmp("R10", "empty after drain", DW'(empty[2]), DW'(1));
      // R10: push and read of the same FIFO in one cycle
      step(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 16'h3000, "R10 seed");
      step(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 16'h3001, "R10 push+read");
      cmp("R10", "same cycle", bus_data, 16'h3001);
      // R8: pointers of other FIFOs unaffected
      idle(2'd0, 1'b0, "R8 independent");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [1:0] s;
         s = 2'($urandom_range(0, 3));
         step(s, ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0),
              ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1),
              2'($urandom_range(0, 3)), DW'($urandom), "random");
         if (n % 500 == 499) begin
            rst = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rst = 1'b0;
            model_reset();
            cmp("R1", "mid reset", DW'(empty), DW'({NF{1'b1}}));
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule